// File: doc/BRIEF.md
# Core Isolation Wrapper

This block is the collar that surrounds an embedded core so the core can be exercised on its own or its surrounding wiring can be tested without it. Every core input terminal and every core output terminal gets a boundary cell. All cells are linked into one serial chain. A two-bit instruction, loaded bit by bit over the same serial input, chooses how the cells behave.

In functional mode the host and the core see each other directly. In interconnect mode the output cells drive the host side and the input cells record what the host presents. In core mode the input cells drive the core and the output cells record the core's answers. A fourth code shortens the serial path to a single flop so the wrapper can be passed through quickly. Every cell has a shift flop and a separate update stage, so driven values change only when an update is requested and never while data moves along the chain.

All controls are sampled on the rising clock edge. Shift takes priority over capture, and capture and update act only when shift is low.

Top module: `ctw_collar`

## Requirements
- R1: After reset the instruction is functional (00), every shift and update flop is 0, core_in equals host_in, host_out equals core_out, and wso is 0.
- R2: With instruction 00, core_in follows host_in and host_out follows core_out for every input value, with no clock needed.
- R3: With sel_ir high, each shift cycle moves wsi into the MSB of the 2-bit instruction shift register, so it is loaded LSB first, and wso shows its bit 0. An update cycle with sel_ir high makes it the active instruction: 00 functional, 01 interconnect, 10 core, 11 bypass. A capture cycle with sel_ir high reloads it with the active code.
- R4: With sel_ir low and an instruction other than 11, the chain is N_IN+N_OUT cells long. Input cell 0 takes wsi, input cells come before output cells, and wso is the last output cell. A bit shifted in reaches wso after N_IN+N_OUT shifts.
- R5: Shifting never changes core_in or host_out. Driven values change only on an update cycle.
- R6: With instruction 01, a capture cycle loads host_in into the input cells (cell i takes host_in[i]) and leaves the output cells unchanged.
- R7: With instruction 01, host_out is driven from the output cells' update stages and core_in equals host_in.
- R8: With instruction 10, core_in is driven from the input cells' update stages and host_out equals core_out.
- R9: With instruction 10, a capture cycle loads core_out into the output cells (cell N_IN+j takes core_out[j]) and leaves the input cells unchanged.
- R10: With instruction 11, wso is wsi delayed by one shift cycle, a capture cycle clears that flop, the chain contents are kept, and core_in and host_out behave as in functional mode.
- R11: When shift is asserted together with capture or update, only the shift takes effect.
- R12: While sel_ir is high, the data chain and the update stages keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test and wrapper clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_in | input | N_IN | Host-side signals headed for the core inputs |
| core_in | output | N_IN | Values applied to the core input terminals |
| core_out | input | N_OUT | Core output terminals |
| host_out | output | N_OUT | Values delivered to the host side |
| wsi | input | 1 | Wrapper serial input |
| wso | output | 1 | Wrapper serial output |
| sel_ir | input | 1 | High: serial controls act on the instruction register |
| shift_en | input | 1 | Shift one position along the selected path |
| capture_en | input | 1 | Load observed values into the selected path |
| update_en | input | 1 | Transfer shifted contents to the update stages or the instruction |

## Verification
core_in and host_out come from the update stages through a mode mux, so they take a new value in the same edge as an update cycle, and the bench reads them one time unit after that edge. wso is sampled after the controls are driven and before the shifting edge, so each read shows the cell that is about to move. A captured value becomes visible only after N_IN+N_OUT shifts, and the bench compares a whole scan-out against the value expected at capture time. An instruction takes effect at its update edge, and every check that depends on it comes after that edge.

// File: rtl/ctw_pkg.sv
package ctw_pkg;
   localparam int unsigned IR_W = 2;

   typedef enum logic [IR_W-1:0] {
      MODE_FUNC   = 2'b00,
      MODE_EXTEST = 2'b01,
      MODE_INTEST = 2'b10,
      MODE_BYPASS = 2'b11
   } ctw_mode_e;
endpackage

// File: rtl/ctw_cell.sv
module ctw_cell #(
   parameter bit HAS_UPD = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic si,
   input  logic shift,
   input  logic cap,
   input  logic upd,
   input  logic cap_d,
   output logic so,
   output logic uq
);
   logic sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sh_q <= 1'b0;
      else if (shift) sh_q <= si;
      else if (cap)   sh_q <= cap_d;
   end

   assign so = sh_q;

   generate
      if (HAS_UPD) begin : g_upd
         logic up_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   up_q <= 1'b0;
            else if (upd) up_q <= sh_q;
         end
         assign uq = up_q;
      end else begin : g_thru
         logic unused_upd;
         assign unused_upd = upd;
         assign uq = sh_q;
      end
   endgenerate
endmodule

// File: rtl/ctw_chain.sv
module ctw_chain #(
   parameter int unsigned N_IN    = 3,
   parameter int unsigned N_OUT   = 2,
   parameter bit          HAS_UPD = 1'b1,
   localparam int unsigned TOT    = N_IN + N_OUT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             si,
   input  logic             shift,
   input  logic             cap_in,
   input  logic             cap_out,
   input  logic             upd,
   input  logic [N_IN-1:0]  host_in,
   input  logic [N_OUT-1:0] core_out,
   output logic [TOT-1:0]   sh_vec,
   output logic [TOT-1:0]   up_vec
);
   genvar i;
   generate
      for (i = 0; i < TOT; i++) begin : g_cell
         logic c_si, c_cap, c_d;
         if (i == 0) begin : g_head
            assign c_si = si;
         end else begin : g_link
            assign c_si = sh_vec[i-1];
         end
         if (i < N_IN) begin : g_in
            assign c_cap = cap_in;
            assign c_d   = host_in[i];
         end else begin : g_out
            assign c_cap = cap_out;
            assign c_d   = core_out[i-N_IN];
         end
         ctw_cell #(.HAS_UPD(HAS_UPD)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .si    (c_si),
            .shift (shift),
            .cap   (c_cap),
            .upd   (upd),
            .cap_d (c_d),
            .so    (sh_vec[i]),
            .uq    (up_vec[i])
         );
      end
   endgenerate
endmodule

// File: rtl/ctw_instr.sv
module ctw_instr
   import ctw_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            si,
   input  logic            shift,
   input  logic            cap,
   input  logic            upd,
   output logic [IR_W-1:0] ir_sh,
   output ctw_mode_e       mode
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ir_sh <= '0;
         mode  <= MODE_FUNC;
      end else if (shift) begin
         ir_sh <= {si, ir_sh[IR_W-1:1]};
      end else if (cap) begin
         ir_sh <= mode;
      end else if (upd) begin
         mode  <= ctw_mode_e'(ir_sh);
      end
   end
endmodule

// File: rtl/ctw_collar.sv
module ctw_collar
   import ctw_pkg::*;
#(
   parameter int unsigned N_IN    = 3,
   parameter int unsigned N_OUT   = 2,
   parameter bit          HAS_UPD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_IN-1:0]  host_in,
   output logic [N_IN-1:0]  core_in,
   input  logic [N_OUT-1:0] core_out,
   output logic [N_OUT-1:0] host_out,
   input  logic             wsi,
   output logic             wso,
   input  logic             sel_ir,
   input  logic             shift_en,
   input  logic             capture_en,
   input  logic             update_en
);
   localparam int unsigned TOT = N_IN + N_OUT;

   generate
      if (N_IN < 1 || N_OUT < 1) begin : g_bad_size
         $error("ctw_collar: N_IN and N_OUT must both be at least 1");
      end
   endgenerate

   ctw_mode_e       mode_q;
   logic [IR_W-1:0] ir_sh_q;
   logic [TOT-1:0]  sh_vec, up_vec;
   logic            byp_q;
   logic            d_sel, is_byp;
   logic            d_shift, d_upd, cap_in, cap_out;

   assign d_sel   = !sel_ir && !shift_en;
   assign is_byp  = (mode_q == MODE_BYPASS);
   assign d_shift = shift_en && !sel_ir && !is_byp;
   assign d_upd   = update_en && d_sel && !is_byp;
   assign cap_in  = capture_en && d_sel && (mode_q == MODE_EXTEST);
   assign cap_out = capture_en && d_sel && (mode_q == MODE_INTEST);

   ctw_instr u_ir (
      .clk   (clk),
      .rst_n (rst_n),
      .si    (wsi),
      .shift (shift_en && sel_ir),
      .cap   (capture_en && sel_ir),
      .upd   (update_en && sel_ir),
      .ir_sh (ir_sh_q),
      .mode  (mode_q)
   );

   ctw_chain #(.N_IN(N_IN), .N_OUT(N_OUT), .HAS_UPD(HAS_UPD)) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .si       (wsi),
      .shift    (d_shift),
      .cap_in   (cap_in),
      .cap_out  (cap_out),
      .upd      (d_upd),
      .host_in  (host_in),
      .core_out (core_out),
      .sh_vec   (sh_vec),
      .up_vec   (up_vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   byp_q <= 1'b0;
      else if (is_byp && !sel_ir && shift_en)       byp_q <= wsi;
      else if (is_byp && d_sel && capture_en)       byp_q <= 1'b0;
   end

   always_comb begin
      if (sel_ir)      wso = ir_sh_q[0];
      else if (is_byp) wso = byp_q;
      else             wso = sh_vec[TOT-1];
   end

   assign core_in  = (mode_q == MODE_INTEST) ? up_vec[N_IN-1:0]  : host_in;
   assign host_out = (mode_q == MODE_EXTEST) ? up_vec[TOT-1:N_IN] : core_out;
endmodule

// File: rtl/ctw_collar_chk.sv
module ctw_collar_chk #(
   parameter int unsigned N_IN  = 3,
   parameter int unsigned N_OUT = 2,
   localparam int unsigned TOT  = N_IN + N_OUT
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_IN-1:0]  host_in,
   input logic [N_IN-1:0]  core_in,
   input logic [N_OUT-1:0] core_out,
   input logic [N_OUT-1:0] host_out,
   input logic             wsi,
   input logic             wso,
   input logic             sel_ir,
   input logic             shift_en,
   input logic             capture_en,
   input logic             update_en,
   input logic [1:0]       mode,
   input logic [1:0]       ir_sh,
   input logic [TOT-1:0]   sh_vec
);
   p_ir_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_ir && update_en && !shift_en && !capture_en) |=> (mode == $past(ir_sh)));

   p_intest_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10 && !update_en) |=> (mode != 2'b10 || $stable(core_in)));

   p_extest_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && !update_en) |=> (mode != 2'b01 || $stable(host_out)));

   p_ext_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_ir && capture_en && !shift_en && mode == 2'b01)
      |=> (sh_vec[N_IN-1:0] == $past(host_in)));

   p_bypass_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_ir && shift_en && mode == 2'b11)
      |=> (sel_ir || mode != 2'b11 || wso == $past(wsi)));

   p_chain_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      sel_ir |=> $stable(sh_vec));
endmodule

bind ctw_collar ctw_collar_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_in    (host_in),
   .core_in    (core_in),
   .core_out   (core_out),
   .host_out   (host_out),
   .wsi        (wsi),
   .wso        (wso),
   .sel_ir     (sel_ir),
   .shift_en   (shift_en),
   .capture_en (capture_en),
   .update_en  (update_en),
   .mode       (mode_q),
   .ir_sh      (ir_sh_q),
   .sh_vec     (sh_vec)
);

// File: tb/sim_ctw_collar.sv
`timescale 1ns/1ps
module sim_ctw_collar;
   localparam int NI = 3;
   localparam int NO = 2;
   localparam int T  = NI + NO;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n;
   logic [NI-1:0] host_in, core_in;
   logic [NO-1:0] core_out, host_out;
   logic          wsi, wso, sel_ir, shift_en, capture_en, update_en;

   ctw_collar #(.N_IN(NI), .N_OUT(NO)) u0 (
      .clk(clk), .rst_n(rst_n), .host_in(host_in), .core_in(core_in),
      .core_out(core_out), .host_out(host_out), .wsi(wsi), .wso(wso),
      .sel_ir(sel_ir), .shift_en(shift_en), .capture_en(capture_en),
      .update_en(update_en)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // bench-side expectation state, built from the requirements
   logic [T-1:0] m_sh, m_up;
   logic [1:0]   m_mode, m_ir;
   logic         m_byp;

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_ports(input string tag);
      chk(tag, 8'(core_in),  8'((m_mode == 2'b10) ? m_up[NI-1:0] : host_in));
      chk(tag, 8'(host_out), 8'((m_mode == 2'b01) ? m_up[T-1:NI] : core_out));
   endtask

   task automatic step(input logic sh, input logic cap, input logic upd,
                       input logic sir, input logic si, output logic pre);
      logic [T-1:0] old;
      @(negedge clk);
      shift_en = sh; capture_en = cap; update_en = upd; sel_ir = sir; wsi = si;
      #1 pre = wso;
      @(posedge clk);
      old = m_sh;
      if (sir) begin
         if (sh)       m_ir = {si, m_ir[1]};
         else if (cap) m_ir = m_mode;
         else if (upd) m_mode = m_ir;
      end else if (m_mode == 2'b11) begin
         if (sh)       m_byp = si;
         else if (cap) m_byp = 1'b0;
      end else if (sh) begin
         m_sh = {old[T-2:0], si};
      end else begin
         if (cap && m_mode == 2'b01) m_sh[NI-1:0] = host_in;
         if (cap && m_mode == 2'b10) m_sh[T-1:NI] = core_out;
         if (upd) m_up = old;
      end
      #1;
      shift_en = 0; capture_en = 0; update_en = 0; sel_ir = 0; wsi = 0;
   endtask

   task automatic load_ir(input logic [1:0] code);
      logic d;
      step(1, 0, 0, 1, code[0], d);
      step(1, 0, 0, 1, code[1], d);
      step(0, 0, 1, 1, 1'b0, d);
   endtask

   task automatic scan(input logic [T-1:0] din, output logic [T-1:0] got);
      for (int k = 0; k < T; k++) begin
         logic b;
         step(1, 0, 0, 0, din[T-1-k], b);
         got[T-1-k] = b;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [T-1:0] got, prev, keep;
      logic b;
      rst_n = 0; host_in = 0; core_out = 0; wsi = 0; sel_ir = 0;
      shift_en = 0; capture_en = 0; update_en = 0;
      m_sh = 0; m_up = 0; m_mode = 0; m_ir = 0; m_byp = 0;
      host_in = 3'b101; core_out = 2'b10;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 core_in", 8'(core_in), 8'(3'b101));
      chk("R1 host_out", 8'(host_out), 8'(2'b10));
      chk("R1 wso", 8'(wso), 8'd0);

      // R2 functional mode, every input combination
      for (int h = 0; h < 8; h++)
         for (int c = 0; c < 4; c++) begin
            host_in = 3'(h); core_out = 2'(c);
            #0.2;
            chk("R2 core_in", 8'(core_in), 8'(h));
            chk("R2 host_out", 8'(host_out), 8'(c));
         end

      // R4 chain length, order and serial delay: every pattern
      prev = '0;
      for (int p = 0; p < 32; p++) begin
         scan(5'(p), got);
         chk("R4 scan", 8'(got), 8'(prev));
         prev = 5'(p);
      end
      chk_ports("R5 no update in functional");

      // R3 instruction load and shift-out
      keep = prev;
      step(1, 0, 0, 1, 1'b1, b);
      step(1, 0, 0, 1, 1'b0, b);
      @(negedge clk); sel_ir = 1; #0.2;
      chk("R3 ir shift-out", 8'(wso), 8'd1);
      sel_ir = 0;
      step(0, 0, 1, 1, 1'b0, b);
      host_in = 3'b011; core_out = 2'b01; #0.2;
      chk("R3 mode 01 active", 8'(m_mode), 8'd1);
      // R12 chain unchanged by instruction traffic
      scan(5'b10110, got);
      chk("R12 chain kept", 8'(got), 8'(keep));

      // R7 / R5 interconnect drive
      step(0, 0, 1, 0, 1'b0, b);
      chk("R7 host_out", 8'(host_out), 8'(2'b10));
      chk("R7 core_in", 8'(core_in), 8'(3'b011));
      scan(5'b01001, got);
      chk("R5 extest stable", 8'(host_out), 8'(2'b10));
      step(0, 0, 1, 0, 1'b0, b);
      chk("R7 host_out updated", 8'(host_out), 8'(2'b01));
      chk_ports("R7 ports");

      // R6 capture of host_in in interconnect mode, all values
      for (int h = 0; h < 8; h++) begin
         host_in = 3'(h);
         scan(5'b11000, got);
         step(0, 1, 0, 0, 1'b0, b);
         scan(5'b00000, got);
         chk("R6 inputs captured", 8'(got[NI-1:0]), 8'(h));
         chk("R6 outputs kept", 8'(got[T-1:NI]), 8'(2'b11));
      end

      // R8 / R9 core mode
      load_ir(2'b10);
      scan(5'b10101, got);
      chk_ports("R5 intest before update");
      step(0, 0, 1, 0, 1'b0, b);
      core_out = 2'b11; #0.2;
      chk("R8 core_in", 8'(core_in), 8'(3'b101));
      chk("R8 host_out", 8'(host_out), 8'(2'b11));
      for (int c = 0; c < 4; c++) begin
         core_out = 2'(c);
         scan(5'b00110, got);
         step(0, 1, 0, 0, 1'b0, b);
         scan(5'b00000, got);
         chk("R9 outputs captured", 8'(got[T-1:NI]), 8'(c));
         chk("R9 inputs kept", 8'(got[NI-1:0]), 8'(3'b110));
      end

      // R11 shift wins over capture and update
      scan(5'b00111, got);
      step(0, 0, 1, 0, 1'b0, b);
      chk("R11 pre core_in", 8'(core_in), 8'(3'b111));
      core_out = 2'b10;
      step(1, 1, 1, 0, 1'b0, b);
      chk("R11 no update", 8'(core_in), 8'(3'b111));
      scan(5'b00000, got);
      chk("R11 shift only", 8'(got), 8'(5'b01110));

      // R10 bypass
      scan(5'b11010, got);
      keep = 5'b11010;
      load_ir(2'b11);
      host_in = 3'b100; core_out = 2'b01; #0.2;
      chk("R10 core_in", 8'(core_in), 8'(3'b100));
      chk("R10 host_out", 8'(host_out), 8'(2'b01));
      prev[0] = m_byp;
      for (int k = 0; k < 6; k++) begin
         logic bit_in;
         bit_in = logic'((k * 5 + 1) % 3 == 0);
         step(1, 0, 0, 0, bit_in, b);
         chk("R10 one-flop path", 8'(b), 8'(prev[0]));
         prev[0] = bit_in;
      end
      step(0, 1, 0, 0, 1'b0, b);
      @(negedge clk); #0.2;
      chk("R10 capture clears", 8'(wso), 8'd0);
      load_ir(2'b00);
      scan(5'b00000, got);
      chk("R10 chain kept", 8'(got), 8'(keep));
      chk_ports("R2 after bypass");

      finish_run();
   end
endmodule